// File: doc/BRIEF.md
# Single-to-Half Precision Converter

This block turns an IEEE binary32 word into an IEEE binary16 word in a two-stage pipeline. A word comes in with a valid strobe, and the converted word leaves with its own valid strobe exactly two clock cycles later. A new word may be accepted every cycle.

Each word carries its own rounding-mode bit, so the mode may change from one word to the next. The two modes are half-up (ties rounded away from zero in magnitude) and round-to-nearest with ties to even. The converter handles these cases:

- zeros
- normal values
- values too large for binary16, which become infinity
- values that land in the binary16 subnormal range, produced by a variable right shift of the mantissa with its hidden bit
- infinities
- NaNs

Input subnormals become signed zero. Every NaN becomes one fixed quiet NaN, and its sign is kept.

The first stage classifies the input and rebiases the exponent. The second stage shifts, rounds and packs the result.

Top module: `f2h_conv`

## Requirements
- R1: An input with exponent field 255 and a nonzero fraction gives the quiet NaN `{sign, 5'b11111, 10'b1000000000}`, which is 0x7E00 or 0xFE00.
- R2: An input with exponent field 255 and a zero fraction gives signed infinity, which is 0x7C00 or 0xFC00.
- R3: An input with exponent field 0 (zero or subnormal) gives signed zero, which is 0x0000 or 0x8000.
- R4: When the rebiased exponent (exponent − 112) is 31 or more and the exponent field is not 255, the output is signed infinity.
- R5: In the normal range (rebiased exponent 1..30), the output is the rebiased exponent over the top 10 fraction bits. Input fraction bit 12 is the rounding bit.
- R6: With `mode_i` = 0 (half-up), the 15-bit magnitude is incremented whenever the rounding bit is 1.
- R7: With `mode_i` = 1 (ties-to-even), the magnitude is incremented only when the rounding bit is 1 and either a lower discarded bit is 1 or the truncated result is odd.
- R8: When the rebiased exponent is 0 or below, the 24-bit significand (hidden bit included) is shifted right by 14 − rebiased exponent to give a subnormal. A shift above 24 (input exponent below 102) gives signed zero.
- R9: The rounding increment acts on the whole 15-bit magnitude. A carry therefore turns the largest subnormal into the smallest normal (0x0400), and turns 65520 into infinity.
- R10: `out_valid_o` equals `in_valid_i` from exactly two cycles earlier, and it is low while reset is active.
- R11: `mode_i` is sampled together with each word, so words in consecutive cycles may use different modes.
- R12: The output sign bit 15 equals input sign bit 31 in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word is valid |
| mode_i | input | 1 | 0 = half-up, 1 = ties-to-even |
| in_data_i | input | 32 | binary32 operand |
| out_valid_o | output | 1 | Output word is valid |
| out_data_o | output | 16 | binary16 result |

## Verification
A wrong class latched in stage one shows at the port two cycles later as a whole wrong pattern: an infinity where a NaN belongs, or a nonzero value where zero belongs. A wrong rebiased exponent shows in the same way. A bad shift amount or a bad rounding decision shows only as a one-count or bit-position error in the low magnitude bits, and only for inputs near a tie or in the subnormal range. For that reason, ties, near-ties and subnormal-range inputs are driven in both modes, back to back. A valid strobe that is out of step with the data shows in the cycle after the expected one.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SEXP_W  = 8;
  localparam int SFRAC_W = 23;
  localparam int HEXP_W  = 5;
  localparam int HFRAC_W = 10;
  localparam int SBIAS   = 127;
  localparam int HBIAS   = 15;
  localparam int SIG_W   = SFRAC_W + 1;
  localparam int DROP_W  = SFRAC_W - HFRAC_W;
  localparam int MAG_W   = HEXP_W + HFRAC_W;
  localparam int HEXP_MAX = (1 << HEXP_W) - 1;
  localparam int MAX_SH  = SIG_W;
  localparam int SH_W    = $clog2(MAX_SH + 1);

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_INF, CLS_NAN, CLS_NORM, CLS_SUB
  } f2h_cls_e;

  typedef struct packed {
    logic              sign;
    logic              even;
    f2h_cls_e          cls;
    logic [HEXP_W-1:0] exp;
    logic [SIG_W-1:0]  sig;
    logic [SH_W-1:0]   shift;
  } f2h_s1_t;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic        mode_i,
  input  logic [31:0] data_i,
  output f2h_s1_t     s1_o
);
  logic [SEXP_W-1:0]  e;
  logic [SFRAC_W-1:0] f;
  logic signed [9:0]  newexp;
  logic signed [9:0]  sh;

  assign e      = data_i[30:23];
  assign f      = data_i[22:0];
  assign newexp = $signed({2'b00, e}) - 10'(SBIAS - HBIAS);
  assign sh     = 10'(DROP_W + 1) - newexp;

  always_comb begin
    s1_o       = '0;
    s1_o.sign  = data_i[31];
    s1_o.even  = mode_i;
    s1_o.sig   = {1'b1, f};
    if (e == '0) begin
      s1_o.cls = CLS_ZERO;
    end else if (e == '1) begin
      s1_o.cls = (f != '0) ? CLS_NAN : CLS_INF;
    end else if (newexp >= 10'(HEXP_MAX)) begin
      s1_o.cls = CLS_INF;
    end else if (newexp <= 10'sd0) begin
      if (sh > 10'(MAX_SH)) begin
        s1_o.cls = CLS_ZERO;
      end else begin
        s1_o.cls   = CLS_SUB;
        s1_o.shift = sh[SH_W-1:0];
      end
    end else begin
      s1_o.cls = CLS_NORM;
      s1_o.exp = newexp[HEXP_W-1:0];
    end
  end
endmodule

// File: rtl/f2h_round_pack.sv
module f2h_round_pack
  import f2h_pkg::*;
(
  input  f2h_s1_t     s1_i,
  output logic [15:0] data_o
);
  logic [MAG_W-1:0] trunc;
  logic [MAG_W-1:0] mag;
  logic [SIG_W-1:0] shifted;
  logic [SIG_W-1:0] lowmask;
  logic [SIG_W-1:0] rbit_vec;
  logic [SH_W-1:0]  sh_m1;
  logic             rbit;
  logic             sticky;
  logic             inc;

  assign sh_m1    = s1_i.shift - SH_W'(1);
  assign shifted  = s1_i.sig >> s1_i.shift;
  assign rbit_vec = s1_i.sig >> sh_m1;
  assign lowmask  = (SIG_W'(1) << sh_m1) - SIG_W'(1);

  always_comb begin
    if (s1_i.cls == CLS_SUB) begin
      trunc  = {{HEXP_W{1'b0}}, shifted[HFRAC_W-1:0]};
      rbit   = rbit_vec[0];
      sticky = |(s1_i.sig & lowmask);
    end else begin
      trunc  = {s1_i.exp, s1_i.sig[SFRAC_W-1:DROP_W]};
      rbit   = s1_i.sig[DROP_W-1];
      sticky = |s1_i.sig[DROP_W-2:0];
    end
  end

  // half-up: any rounding bit; even: needs sticky or odd lsb
  assign inc = rbit & (~s1_i.even | sticky | trunc[0]);
  assign mag = trunc + MAG_W'(inc);

  always_comb begin
    unique case (s1_i.cls)
      CLS_NAN:  data_o = {s1_i.sign, {HEXP_W{1'b1}}, 1'b1, {(HFRAC_W-1){1'b0}}};
      CLS_INF:  data_o = {s1_i.sign, {HEXP_W{1'b1}}, {HFRAC_W{1'b0}}};
      CLS_NORM,
      CLS_SUB:  data_o = {s1_i.sign, mag};
      default:  data_o = {s1_i.sign, {MAG_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/f2h_conv.sv
module f2h_conv
  import f2h_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        mode_i,
  input  logic [31:0] in_data_i,
  output logic        out_valid_o,
  output logic [15:0] out_data_o
);
  f2h_s1_t     s1_d, s1_q;
  logic        s1_vld_q;
  logic [15:0] s2_d;

  f2h_classify u_classify (
    .mode_i (mode_i),
    .data_i (in_data_i),
    .s1_o   (s1_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_q     <= '0;
    end else begin
      s1_vld_q <= in_valid_i;
      if (in_valid_i) s1_q <= s1_d;
    end
  end

  f2h_round_pack u_round_pack (
    .s1_i   (s1_q),
    .data_o (s2_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= s1_vld_q;
      if (s1_vld_q) out_data_o <= s2_d;
    end
  end
endmodule

// File: rtl/f2h_conv_chk.sv
module f2h_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [31:0] in_data_i,
  input logic        out_valid_o,
  input logic [15:0] out_data_o
);
  logic [1:0] since_rst;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign armed = (since_rst == 2'd2);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (out_valid_o == $past(in_valid_i, 2))) else $error("latency"); // R10

  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(in_data_i[30:23], 2) == 8'hFF && $past(in_data_i[22:0], 2) != 23'd0)
    |-> out_data_o[14:0] == 15'h7E00) else $error("nan"); // R1

  AST_INF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(in_data_i[30:0], 2) == 31'h7F800000)
    |-> out_data_o[14:0] == 15'h7C00) else $error("inf"); // R2

  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(in_data_i[30:23], 2) == 8'h00)
    |-> out_data_o[14:0] == 15'h0000) else $error("zero"); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o && $past(in_data_i[30:23], 2) >= 8'd143 && $past(in_data_i[30:23], 2) != 8'hFF)
    |-> out_data_o[14:0] == 15'h7C00) else $error("ovf"); // R4

  AST_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_valid_o) |-> out_data_o[15] == $past(in_data_i[31], 2)) else $error("sign"); // R12
endmodule

bind f2h_conv f2h_conv_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/f2h_conv_bench.sv
module f2h_conv_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  f2h_conv u_f2h_conv (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_valid_i (in_valid_i), .mode_i (mode_i),
    .in_data_i (in_data_i), .out_valid_o (out_valid_o), .out_data_o (out_data_o)
  );

  typedef struct packed {
    logic        m;
    logic [31:0] d;
    logic [15:0] e;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h00000000, 16'h0000, "R3"},
    '{1'b1, 32'h80000000, 16'h8000, "R3"},
    '{1'b1, 32'h00000001, 16'h0000, "R3"},
    '{1'b0, 32'h80400000, 16'h8000, "R3"},
    '{1'b1, 32'h3F800000, 16'h3C00, "R5"},
    '{1'b0, 32'hC0000000, 16'hC000, "R12"},
    '{1'b1, 32'h7F800000, 16'h7C00, "R2"},
    '{1'b0, 32'hFF800000, 16'hFC00, "R2"},
    '{1'b1, 32'h7FC00000, 16'h7E00, "R1"},
    '{1'b0, 32'hFF800001, 16'hFE00, "R1"},
    '{1'b1, 32'h477FE000, 16'h7BFF, "R5"},
    '{1'b1, 32'h47800000, 16'h7C00, "R4"},
    '{1'b0, 32'hC7800000, 16'hFC00, "R4"},
    '{1'b1, 32'h477FF000, 16'h7C00, "R9"},
    '{1'b1, 32'h40001000, 16'h4000, "R7"},
    '{1'b0, 32'h40001000, 16'h4001, "R6"},
    '{1'b1, 32'h40001000, 16'h4000, "R11"},
    '{1'b0, 32'h3F801000, 16'h3C01, "R6"},
    '{1'b1, 32'h3F801000, 16'h3C00, "R7"},
    '{1'b1, 32'h3F803000, 16'h3C02, "R7"},
    '{1'b1, 32'h33800000, 16'h0001, "R8"},
    '{1'b1, 32'h33000000, 16'h0000, "R7"},
    '{1'b0, 32'h33000000, 16'h0001, "R6"},
    '{1'b1, 32'h32800000, 16'h0000, "R8"},
    '{1'b0, 32'h32800000, 16'h0000, "R8"},
    '{1'b1, 32'h387FF000, 16'h0400, "R9"},
    '{1'b1, 32'h387FC000, 16'h03FF, "R8"},
    '{1'b1, 32'h38800000, 16'h0400, "R5"},
    '{1'b1, 32'h33C00000, 16'h0002, "R7"},
    '{1'b0, 32'hB3C00000, 16'h8002, "R12"}
  };

  // behavioural model built from the requirements
  function automatic logic [15:0] model(input logic m, input logic [31:0] x);
    int e, ne, sh;
    longint f, sig, q, rem, half;
    logic up;
    e  = int'(x[30:23]);
    f  = longint'(x[22:0]);
    ne = e - 112;
    if (e == 255) return {x[31], (f != 0) ? 15'h7E00 : 15'h7C00};
    if (e == 0) return {x[31], 15'h0};
    if (ne >= 31) return {x[31], 15'h7C00};
    if (ne <= 0) begin
      sh = 14 - ne;
      if (sh > 24) return {x[31], 15'h0};
      sig = f + 64'h800000;
      q = sig >> sh;
      rem = sig - (q << sh);
      half = 64'd1 << (sh - 1);
    end else begin
      q = (longint'(ne) << 10) + (f >> 13);
      rem = f & 64'h1FFF;
      half = 64'h1000;
    end
    up = (rem > half) || (rem == half && (!m || q[0]));
    q = q + (up ? 64'd1 : 64'd0);
    return {x[31], q[14:0]};
  endfunction

  logic        ev1 = 1'b0, ev2 = 1'b0;
  logic [15:0] ed1 = '0, ed2 = '0;
  logic [31:0] ei1 = '0, ei2 = '0;
  logic [23:0] et1 = "", et2 = "";

  task automatic check_out();
    checks++;
    if (out_valid_o !== ev2) begin
      errors++;
      $display("FAIL R10 valid: actual=%b expected=%b", out_valid_o, ev2);
    end else if (ev2 && out_data_o !== ed2) begin
      errors++;
      $display("FAIL %s in=%08h: actual=%04h expected=%04h", et2, ei2, out_data_o, ed2);
    end
  endtask

  // call at negedge: check the word issued two steps back, then drive the next
  task automatic step(input logic v, input logic m, input logic [31:0] d,
                      input logic [15:0] e, input logic [23:0] t);
    check_out();
    ev2 = ev1; ed2 = ed1; ei2 = ei1; et2 = et1;
    ev1 = v;   ed1 = e;   ei1 = d;   et1 = t;
    in_valid_i = v; mode_i = m; in_data_i = d;
    @(negedge clk_i);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 32'h0, 16'h0, "R10");
  endtask

  task automatic rand_word(input logic m, input bit biased);
    logic [31:0] x;
    x = $urandom;
    if (biased) x[30:23] = 8'(95 + ($urandom % 52));
    step(1'b1, m, x, model(m, x), m ? "R7" : "R6");
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || out_data_o !== 16'h0) begin
      errors++;
      $display("FAIL R10 reset: actual=%b/%04h expected=0/0000", out_valid_o, out_data_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table, back to back, mixed modes (R11)
    for (int i = 0; i < NV; i++) begin
      checks++;
      if (model(VECS[i].m, VECS[i].d) !== VECS[i].e) begin
        errors++;
        $display("FAIL %s model in=%08h: actual=%04h expected=%04h", VECS[i].tag,
                 VECS[i].d, model(VECS[i].m, VECS[i].d), VECS[i].e);
      end
      step(1'b1, VECS[i].m, VECS[i].d, VECS[i].e, VECS[i].tag);
    end
    flush();

    // gapped valid stream: R10
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b1, 32'h3F800000 + 32'(i << 13), 16'h3C00 + 16'(i), "R10");
      step(1'b0, 1'b0, 32'hFFFFFFFF, 16'h0, "R10");
    end
    flush();

    // fixed mode runs then per-word switching
    for (int i = 0; i < 600; i++) rand_word(1'b1, 1'b1);
    for (int i = 0; i < 600; i++) rand_word(1'b0, 1'b1);
    for (int i = 0; i < 600; i++) rand_word(1'(i), i[1]);
    flush();

    // reset with words in flight: R10
    step(1'b1, 1'b0, 32'h3F800000, 16'h3C00, "R10");
    in_valid_i = 1'b1;
    rst_ni = 1'b0;
    @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 mid reset: actual=%b expected=0", out_valid_o);
    end
    in_valid_i = 1'b0;
    rst_ni = 1'b1;
    ev1 = 1'b0; ev2 = 1'b0;
    @(negedge clk_i);
    flush();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule